// File: doc/BRIEF.md
# Address-space-tagged translation cache

This block turns a virtual address into a physical address for a paged memory with a single-level page table. The address splits into a virtual page number in its upper bits and a byte offset in its lower bits. The page number is compared with all eight cached translations at the same time. Each cached translation also carries an address-space tag, and a cached translation is used only when its tag matches the requester's current process tag. On a match, the physical address is the cached frame number placed above the unchanged offset, and it is returned in the same cycle.

On a miss, the block reads one page-table word from memory at the table base plus the page number. If the word is marked valid, its frame is written into a slot chosen in rotating order. The pending lookup is then repeated automatically, with no new request. A page number at or above the table length register faults at once and makes no memory access. A word marked invalid also faults, and nothing is cached for it. A flush input empties the whole cache in one cycle.

The requester holds `req_valid` and the request fields steady until it sees `resp_hit` or `fault`, and drops `req_valid` in that same cycle.

Top module: `tlb_xlate`

## Requirements
- R1: The virtual address is split into a page number in `req_vaddr[15:8]` and an offset in `req_vaddr[7:0]`. On a hit, `resp_paddr` is `{frame[7:0], offset}` in the same cycle that `req_valid` is presented.
- R2: A cached translation hits only when both the page number and `req_asid` match the values stored with it. The same page requested under another tag is a miss.
- R3: A miss sets `mem_rd_en` for exactly one cycle, the cycle after the miss, with `mem_rd_addr` equal to `pt_base + page number`. The read data is taken in a later cycle, when `mem_rd_valid` is high.
- R4: A page-table word has its valid flag in bit 15 and its frame in bits 7:0. A valid word is installed, and the held lookup then hits three cycles after it was first presented, with no new request.
- R5: A page number greater than or equal to `pt_len` raises `fault` in the same cycle and never raises `resp_hit` or `mem_rd_en`. Page number `pt_len-1` is not a length fault.
- R6: A page-table word with bit 15 clear raises `fault` for one cycle, three cycles after the lookup. Nothing is installed, so a repeat of that lookup reads memory again.
- R7: Fills go to slots 0, 1, … 7 and then wrap to slot 0, one slot per fill. The ninth fill after reset evicts the first translation installed.
- R8: A one-cycle pulse on `flush` invalidates every cached translation. Every later lookup misses until it has been filled again.
- R9: While `rst` is high, and in the first cycle after it falls, `resp_hit`, `fault`, `busy` and `mem_rd_en` are low.
- R10: `busy` is high during the two cycles of a page-table read. While `busy` is high, `resp_hit` stays low and no other read is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cached translations |
| req_valid | input | 1 | Lookup request, held until hit or fault |
| req_vaddr | input | 16 | Virtual address |
| req_asid | input | 4 | Current address-space tag |
| pt_base | input | 16 | Word address of the page table |
| pt_len | input | 9 | Number of legal pages |
| resp_hit | output | 1 | Translation valid this cycle |
| resp_paddr | output | 16 | Physical address, zero unless hit |
| fault | output | 1 | Length or invalid-entry fault |
| busy | output | 1 | Page-table read in progress |
| mem_rd_en | output | 1 | Page-table read request |
| mem_rd_addr | output | 16 | Page-table word address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 16 | Page-table word |

## Verification
Directed lookups exercise a first-time miss, a repeat of it, and the same page under a second tag. This separates tag matching from page matching. Page numbers at `pt_len-1` and `pt_len`, and a page whose table word is invalid, are used to tell the length fault (immediate, no read) apart from the entry fault (after a read, nothing cached). Nine distinct fills after a flush show the rotating victim choice. Random lookups then draw from a pool slightly larger than the cache, spread over three tags with occasional flushes, and each outcome, latency, address and read count is compared with a reference model kept in the bench.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;
  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_ISSUE = 2'd1,
    W_WAIT  = 2'd2,
    W_PFLT  = 2'd3
  } walk_state_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int VPN_W   = 8,
  parameter int FRAME_W = 8,
  parameter int ASID_W  = 4,
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  lk_asid,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [ASID_W-1:0]  fill_asid,
  input  logic [FRAME_W-1:0] fill_frame
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   tag_vpn   [ENTRIES];
  logic [ASID_W-1:0]  tag_asid  [ENTRIES];
  logic [FRAME_W-1:0] frame_mem [ENTRIES];
  logic [PTR_W-1:0]   ptr;
  logic [ENTRIES-1:0] hit_vec;
  logic               fill_go;

  assign fill_go = fill_en && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      ptr <= '0;
    end else if (flush) begin
      vld <= '0;
    end else if (fill_go) begin
      vld[ptr] <= 1'b1;
      ptr      <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_vpn[ptr]   <= fill_vpn;
      tag_asid[ptr]  <= fill_asid;
      frame_mem[ptr] <= fill_frame;
    end
  end

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
    assign hit_vec[gi] = vld[gi] && (tag_vpn[gi] == lk_vpn) && (tag_asid[gi] == lk_asid);
  end

  always_comb begin
    lk_frame = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) lk_frame = lk_frame | frame_mem[i];
    end
  end

  assign lk_hit = |hit_vec;

  // R2: a page/tag pair is never cached twice
  a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
  // R7: an accepted fill occupies the slot the pointer named
  a_r7_fill_sets_slot: assert property (@(posedge clk) disable iff (rst)
    fill_go |=> vld[$past(ptr)]);
  // R7: the victim pointer only moves on a fill
  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    !fill_go |=> $stable(ptr));
  // R8: a flush leaves nothing cached
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld == '0));
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
  import tlb_xlate_pkg::*;
#(
  parameter int VPN_W   = 8,
  parameter int FRAME_W = 8,
  parameter int ASID_W  = 4,
  parameter int MEM_AW  = 16,
  parameter int MEM_DW  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               start,
  input  logic [VPN_W-1:0]   st_vpn,
  input  logic [ASID_W-1:0]  st_asid,
  input  logic [MEM_AW-1:0]  pt_base,
  output logic               mem_rd_en,
  output logic [MEM_AW-1:0]  mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [MEM_DW-1:0]  mem_rd_data,
  output logic               idle,
  output logic               busy,
  output logic               pte_fault,
  output logic               fill_en,
  output logic [VPN_W-1:0]   fill_vpn,
  output logic [ASID_W-1:0]  fill_asid,
  output logic [FRAME_W-1:0] fill_frame
);
  walk_state_e       state;
  logic [MEM_AW-1:0] addr_q;
  logic              pte_ok;
  logic              unused_pte_bits;

  assign pte_ok          = mem_rd_data[MEM_DW-1];
  assign unused_pte_bits = ^mem_rd_data[MEM_DW-2:FRAME_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= W_IDLE;
      addr_q    <= '0;
      fill_vpn  <= '0;
      fill_asid <= '0;
    end else begin
      case (state)
        W_IDLE: if (start) begin
          state     <= W_ISSUE;
          addr_q    <= pt_base + MEM_AW'(st_vpn);
          fill_vpn  <= st_vpn;
          fill_asid <= st_asid;
        end
        W_ISSUE: state <= W_WAIT;
        W_WAIT: if (mem_rd_valid) state <= pte_ok ? W_IDLE : W_PFLT;
        default: state <= W_IDLE;
      endcase
    end
  end

  assign mem_rd_en   = (state == W_ISSUE);
  assign mem_rd_addr = addr_q;
  assign idle        = (state == W_IDLE);
  assign busy        = (state == W_ISSUE) || (state == W_WAIT);
  assign pte_fault   = (state == W_PFLT);
  assign fill_en     = (state == W_WAIT) && mem_rd_valid && pte_ok && !flush;
  assign fill_frame  = mem_rd_data[FRAME_W-1:0];

  // R3: a read request lasts one cycle
  a_r3_single_read: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);
  // R3: an accepted miss issues its read in the next cycle
  a_r3_read_follows_start: assert property (@(posedge clk) disable iff (rst)
    (start && idle) |=> mem_rd_en);
  // R6: an invalid table word is reported in the next cycle
  a_r6_bad_word_faults: assert property (@(posedge clk) disable iff (rst)
    ((state == W_WAIT) && mem_rd_valid && !pte_ok) |=> pte_fault);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int VA_W    = 16,
  parameter int OFF_W   = 8,
  parameter int FRAME_W = 8,
  parameter int ASID_W  = 4,
  parameter int ENTRIES = 8,
  parameter int MEM_AW  = 16,
  parameter int MEM_DW  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     req_valid,
  input  logic [VA_W-1:0]          req_vaddr,
  input  logic [ASID_W-1:0]        req_asid,
  input  logic [MEM_AW-1:0]        pt_base,
  input  logic [VA_W-OFF_W:0]      pt_len,
  output logic                     resp_hit,
  output logic [FRAME_W+OFF_W-1:0] resp_paddr,
  output logic                     fault,
  output logic                     busy,
  output logic                     mem_rd_en,
  output logic [MEM_AW-1:0]        mem_rd_addr,
  input  logic                     mem_rd_valid,
  input  logic [MEM_DW-1:0]        mem_rd_data
);
  localparam int VPN_W = VA_W - OFF_W;

  logic [VPN_W-1:0]   vpn;
  logic [OFF_W-1:0]   off;
  logic               cam_hit;
  logic [FRAME_W-1:0] cam_frame;
  logic               len_bad, lookup_act, start_walk, w_idle, pte_fault;
  logic               fill_en;
  logic [VPN_W-1:0]   fill_vpn;
  logic [ASID_W-1:0]  fill_asid;
  logic [FRAME_W-1:0] fill_frame;

  assign vpn        = req_vaddr[VA_W-1:OFF_W];
  assign off        = req_vaddr[OFF_W-1:0];
  assign len_bad    = ({1'b0, vpn} >= pt_len);
  assign lookup_act = req_valid && w_idle;
  assign resp_hit   = lookup_act && cam_hit && !len_bad;
  assign resp_paddr = resp_hit ? {cam_frame, off} : '0;
  assign fault      = (lookup_act && len_bad) || pte_fault;
  assign start_walk = lookup_act && !cam_hit && !len_bad && !flush;

  tlb_cam #(
    .VPN_W(VPN_W), .FRAME_W(FRAME_W), .ASID_W(ASID_W), .ENTRIES(ENTRIES)
  ) cam_i (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_vpn(vpn), .lk_asid(req_asid), .lk_hit(cam_hit), .lk_frame(cam_frame),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_frame(fill_frame)
  );

  tlb_walker #(
    .VPN_W(VPN_W), .FRAME_W(FRAME_W), .ASID_W(ASID_W), .MEM_AW(MEM_AW), .MEM_DW(MEM_DW)
  ) walk_i (
    .clk(clk), .rst(rst), .flush(flush), .start(start_walk),
    .st_vpn(vpn), .st_asid(req_asid), .pt_base(pt_base),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .idle(w_idle), .busy(busy), .pte_fault(pte_fault),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_frame(fill_frame)
  );

  // R10: no translation is reported while a read is pending
  a_r10_no_hit_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !resp_hit);
  // R5: an out-of-range page never reaches memory
  a_r5_len_fault_no_read: assert property (@(posedge clk) disable iff (rst)
    (lookup_act && len_bad) |=> !mem_rd_en);
  // R5: hit and fault are exclusive
  a_r5_fault_excl_hit: assert property (@(posedge clk) disable iff (rst)
    !(fault && resp_hit));
endmodule

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb_top;
  localparam logic [15:0] PT_BASE = 16'h1000;

  logic        clk = 1'b0;
  logic        rst, flush, req_valid;
  logic [15:0] req_vaddr;
  logic [3:0]  req_asid;
  logic [8:0]  pt_len;
  logic        resp_hit, fault, busy, mem_rd_en, mem_rd_valid;
  logic [15:0] resp_paddr, mem_rd_addr, mem_rd_data;

  int checks = 0;
  int fails  = 0;
  int rd_cnt = 0;
  logic [15:0] rd_last = '0;

  logic       m_vld   [8];
  logic [7:0] m_vpn   [8];
  logic [3:0] m_asid  [8];
  logic [7:0] m_frame [8];
  int         m_ptr;

  always #10 clk = ~clk;

  tlb_xlate dut_i (
    .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_asid(req_asid), .pt_base(PT_BASE), .pt_len(pt_len),
    .resp_hit(resp_hit), .resp_paddr(resp_paddr), .fault(fault), .busy(busy),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  function automatic logic [15:0] pte_fn(input logic [15:0] a);
    logic ok;
    ok = (a[3:0] != 4'hF);
    return {ok, 7'd0, a[7:0] ^ 8'hA5 ^ {a[11:8], 4'h0}};
  endfunction

  always @(posedge clk) begin
    mem_rd_valid <= mem_rd_en && !rst;
    mem_rd_data  <= pte_fn(mem_rd_addr);
    if (mem_rd_en) begin
      rd_cnt  <= rd_cnt + 1;
      rd_last <= mem_rd_addr;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < 8; i++) m_vld[i] = 1'b0;
  endtask

  // kind: 0 cached hit, 1 length fault, 2 walk then hit, 3 walk then fault
  task automatic lookup(input logic [7:0] vpn, input logic [7:0] off,
                        input logic [3:0] asid, input string tag);
    int kind, slot, cyc, busy_n, rd0, exp_lat;
    logic [15:0] pte;
    logic [7:0]  efr;
    logic        g_hit, g_flt;
    logic [15:0] g_pa;
    slot = -1;
    efr  = '0;
    for (int i = 0; i < 8; i++)
      if (m_vld[i] && m_vpn[i] == vpn && m_asid[i] == asid) slot = i;
    pte = pte_fn(PT_BASE + {8'd0, vpn});
    if ({1'b0, vpn} >= pt_len) kind = 1;
    else if (slot >= 0) begin kind = 0; efr = m_frame[slot]; end
    else if (!pte[15]) kind = 3;
    else begin kind = 2; efr = pte[7:0]; end
    @(negedge clk);
    rd0 = rd_cnt;
    req_valid = 1'b1;
    req_vaddr = {vpn, off};
    req_asid  = asid;
    #1;
    cyc = 0;
    busy_n = 0;
    while (!resp_hit && !fault && cyc < 10) begin
      if (busy) busy_n++;
      @(negedge clk);
      #1;
      cyc++;
    end
    g_hit = resp_hit;
    g_flt = fault;
    g_pa  = resp_paddr;
    req_valid = 1'b0;
    exp_lat = (kind < 2) ? 0 : 3;
    chk(g_hit == (kind == 0 || kind == 2), tag, "hit", g_hit, (kind == 0 || kind == 2));
    chk(g_flt == (kind == 1 || kind == 3), tag, "fault", g_flt, (kind == 1 || kind == 3));
    chk(cyc == exp_lat, tag, "latency", cyc, exp_lat);
    if (kind == 0 || kind == 2) chk(g_pa == {efr, off}, tag, "paddr", g_pa, {efr, off});
    chk((rd_cnt - rd0) == ((kind >= 2) ? 1 : 0), tag, "reads", rd_cnt - rd0, (kind >= 2));
    if (kind >= 2) begin
      chk(rd_last == PT_BASE + {8'd0, vpn}, tag, "read addr", rd_last, PT_BASE + {8'd0, vpn});
      chk(busy_n == 2, "R10", "busy cycles", busy_n, 2);
    end
    if (kind == 2) begin
      m_vld[m_ptr] = 1'b1;
      m_vpn[m_ptr] = vpn;
      m_asid[m_ptr] = asid;
      m_frame[m_ptr] = efr;
      m_ptr = (m_ptr + 1) % 8;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog (all requirements): actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rv;
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) m_vld[i] = 1'b0;
    m_ptr = 0;
    rst = 1'b1; flush = 1'b0; req_valid = 1'b0;
    req_vaddr = '0; req_asid = '0; pt_len = 9'd200;
    repeat (3) @(negedge clk);
    #1;
    chk(!resp_hit && !fault && !busy && !mem_rd_en, "R9", "outputs in reset",
        {resp_hit, fault, busy, mem_rd_en}, 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!resp_hit && !fault && !busy && !mem_rd_en, "R9", "outputs after reset",
        {resp_hit, fault, busy, mem_rd_en}, 0);

    lookup(8'h03, 8'h44, 4'd1, "R4");   // first miss, fill, retry
    lookup(8'h03, 8'h9C, 4'd1, "R1");   // cached hit, new offset
    lookup(8'h03, 8'h01, 4'd2, "R2");   // other tag misses
    lookup(8'h03, 8'h02, 4'd1, "R2");   // original tag still hits
    lookup(8'hC7, 8'h10, 4'd1, "R5");   // last legal page
    lookup(8'hC8, 8'h10, 4'd1, "R5");   // first illegal page
    lookup(8'hFF, 8'hFF, 4'd3, "R5");
    lookup(8'h0F, 8'h20, 4'd1, "R6");   // invalid table word
    lookup(8'h0F, 8'h21, 4'd1, "R6");   // not cached, read again
    lookup(8'h03, 8'h55, 4'd1, "R3");
    do_flush();
    lookup(8'h03, 8'h55, 4'd1, "R8");   // miss after flush
    do_flush();
    for (int k = 0; k < 9; k++) lookup(8'h20 + 8'(k), 8'h00, 4'd5, "R7");
    lookup(8'h28, 8'h07, 4'd5, "R7");   // ninth fill still cached
    lookup(8'h21, 8'h07, 4'd5, "R7");   // second fill survives
    lookup(8'h20, 8'h07, 4'd5, "R7");   // first fill was evicted

    for (int n = 0; n < 400; n++) begin
      int k;
      if ($urandom_range(0, 39) == 0) do_flush();
      k  = $urandom_range(0, 12);
      rv = (k == 12) ? 8'h2F : 8'(k * 20);
      lookup(rv, 8'($urandom_range(0, 255)), 4'($urandom_range(0, 2)), "R1");
    end

    summary();
    $finish;
  end
endmodule